// File: doc/BRIEF.md
# Processor Debug Register Port

This block sits next to a small 64-bit processor core and gives an external debugger register-level control over it. The debugger issues single accesses on a request/acknowledge bus. Each access carries a 4-bit address, 64-bit write data and a write flag, and each one completes with a one-cycle acknowledge.

Through this port the debugger can halt the core, let it retire one instruction at a time, and release it again. While the core is halted, the debugger can read the next-instruction address, the machine state, the condition register and the packed fixed-point exception flags. General-purpose and special registers are read indirectly: the debugger first writes an index register, then reads a data register that returns the register the index selects.

The core itself is outside the block. It is represented by a halt-request output, a one-cycle step output, a halted input, and a register-select/register-data pair.

Top module: `dbg_port`

## Requirements
- R1: An accepted request (`req` high while `ack` is low and no access is pending) is acknowledged by `ack` high for exactly one cycle, on the cycle after acceptance. Read data on `rdata` is valid in that same cycle. The requester must lower `req` before it starts the next access.
- R2: A write to address 0 with bit 0 set drives `halt_req` high. Status address 1 then reads 2 (bit 1 = stopped) once `core_halted` has been seen high while the halt is requested.
- R3: A write to address 0 with bit 1 set and bit 0 clear lowers `halt_req` and clears the stopped bit. When bits 0 and 1 are both set, the stop wins and `halt_req` stays high.
- R4: A write to address 0 with bit 3 set, while the stopped bit is 1 and bit 1 is clear, raises `step` for one cycle and clears the stopped bit. The stopped bit rises again only after `core_halted` has gone low and then high, so exactly one instruction retires. A step write while not stopped produces no `step` pulse.
- R5: Reads return `nia` at address 2, `msr` at address 3 and `cr` at address 8.
- R6: A read of address 9 returns the exception flags packed as so in bit 0, ca in bit 2, ca32 in bit 3, ov in bit 4 and ov32 in bit 5, with all other bits zero.
- R7: A write to address 4 latches `wdata[7:0]` as the register index. A read of address 4 returns that index. `reg_sel` carries the low 6 bits of the index. A read of address 5 returns `reg_data` when the index is 0 to 45 (0–31 general-purpose, 32–45 special registers in the core's fixed order).
- R8: A read of address 5 returns zero when the latched index is above 45.
- R9: Reads of addresses 0, 6, 7 and 10–15 return zero. Writes to addresses 6, 7 and 10–15 are acknowledged and change neither the index, `halt_req` nor the status.
- R10: After reset, `ack`, `halt_req`, `step` and the stopped bit are 0, and the register index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request |
| addr | input | 4 | Register address |
| wdata | input | 64 | Write data |
| wen | input | 1 | 1 = write, 0 = read |
| ack | output | 1 | One-cycle access completion |
| rdata | output | 64 | Read data, valid with `ack` |
| halt_req | output | 1 | Asks the core to halt |
| step | output | 1 | One-cycle pulse allowing one instruction |
| core_halted | input | 1 | Core reports it is halted |
| nia | input | 64 | Core next-instruction address |
| msr | input | 64 | Core machine state |
| cr | input | 64 | Core condition register |
| xer_so | input | 1 | Summary overflow flag |
| xer_ca | input | 1 | Carry flag |
| xer_ca32 | input | 1 | 32-bit carry flag |
| xer_ov | input | 1 | Overflow flag |
| xer_ov32 | input | 1 | 32-bit overflow flag |
| reg_sel | output | 6 | Register index presented to the core |
| reg_data | input | 64 | Register contents for `reg_sel` |

## Verification
The assertions assume the requester follows the bus rule: `req` drops in the cycle `ack` is seen and stays low for at least one cycle before the next access. They also assume the core lowers `core_halted` within a few cycles of a `step` pulse. The bench drives every access through one task that enforces that handshake. Its core stub answers each step with a fixed three-cycle run before it halts again. Random traffic covers the read addresses, index values inside and outside the register range, and writes to unmapped addresses. Directed sequences cover stop, step, resume, combined stop-and-resume, and a step attempted while the core is running.

// File: rtl/dbg_port.sv
module dbg_port #(
  parameter int DW   = 64,
  parameter int AW   = 4,
  parameter int IW   = 8,
  parameter int NREG = 46,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wen,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic          halt_req,
  output logic          step,
  input  logic          core_halted,
  input  logic [DW-1:0] nia,
  input  logic [DW-1:0] msr,
  input  logic [DW-1:0] cr,
  input  logic          xer_so,
  input  logic          xer_ca,
  input  logic          xer_ca32,
  input  logic          xer_ov,
  input  logic          xer_ov32,
  output logic [SW-1:0] reg_sel,
  input  logic [DW-1:0] reg_data
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_NIA  = AW'(2);
  localparam logic [AW-1:0] A_MSR  = AW'(3);
  localparam logic [AW-1:0] A_IDX  = AW'(4);
  localparam logic [AW-1:0] A_DATA = AW'(5);
  localparam logic [AW-1:0] A_CR   = AW'(8);
  localparam logic [AW-1:0] A_XER  = AW'(9);
  localparam int B_STOP   = 0;
  localparam int B_RESUME = 1;
  localparam int B_STEP   = 3;
  localparam int B_HALTED = 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(NREG - 1);

  logic          pend;
  logic          acc;
  logic          stopped;
  logic          step_busy;
  logic [IW-1:0] idx;
  logic [DW-1:0] rd_mux;
  logic          unused_bits;

  assign acc         = req & ~ack & ~pend;
  assign reg_sel     = idx[SW-1:0];
  assign unused_bits = ^wdata[DW-1:IW];

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_STAT:  rd_mux[B_HALTED] = stopped;
      A_NIA:   rd_mux = nia;
      A_MSR:   rd_mux = msr;
      A_IDX:   rd_mux[IW-1:0] = idx;
      A_DATA:  if (idx <= LAST_IDX) rd_mux = reg_data;
      A_CR:    rd_mux = cr;
      A_XER:   rd_mux[5:0] = {xer_ov32, xer_ov, xer_ca32, xer_ca, 1'b0, xer_so};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack       <= 1'b0;
      pend      <= 1'b0;
      rdata     <= '0;
      halt_req  <= 1'b0;
      step      <= 1'b0;
      stopped   <= 1'b0;
      step_busy <= 1'b0;
      idx       <= '0;
    end else begin
      ack  <= acc;
      step <= 1'b0;
      if (acc) pend <= 1'b1;
      else if (!req) pend <= 1'b0;
      if (acc) rdata <= wen ? '0 : rd_mux;
      if (step_busy && !core_halted) step_busy <= 1'b0;
      if (halt_req && core_halted && !step_busy) stopped <= 1'b1;
      if (acc && wen) begin
        case (addr)
          A_CTRL: begin
            if (wdata[B_STOP]) begin
              halt_req <= 1'b1;
            end else if (wdata[B_RESUME]) begin
              halt_req  <= 1'b0;
              stopped   <= 1'b0;
              step_busy <= 1'b0;
            end
            if (wdata[B_STEP] && stopped && !wdata[B_RESUME]) begin
              step      <= 1'b1;
              stopped   <= 1'b0;
              step_busy <= 1'b1;
            end
          end
          A_IDX:   idx <= wdata[IW-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dbg_port_chk.sv
module dbg_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       acc,
  input logic       ack,
  input logic       wen,
  input logic [3:0] addr,
  input logic [3:0] wctl,
  input logic       halt_req,
  input logic       step
);
  a_r1_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ack);
  a_r1_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  a_r2_stop_sets_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wen && addr == 4'd0 && wctl[0]) |=> halt_req);
  a_r3_resume_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wen && addr == 4'd0 && wctl[1] && !wctl[0]) |=> !halt_req);
  a_r4_step_single: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !step);
  a_r4_step_halted: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> halt_req);
endmodule

bind dbg_port dbg_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc(acc), .ack(ack), .wen(wen),
  .addr(addr), .wctl(wdata[3:0]), .halt_req(halt_req), .step(step)
);

// File: tb/sim_dbg_port.sv
`timescale 1ns/1ps
module sim_dbg_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [3:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic        wen = 1'b0;
  logic        ack;
  logic [63:0] rdata;
  logic        halt_req, step;
  logic        core_halted;
  logic [63:0] nia = '0, msr = '0, cr = '0;
  logic        so = 0, ca = 0, ca32 = 0, ov = 0, ov32 = 0;
  logic [5:0]  reg_sel;
  logic [63:0] reg_data;

  int checks = 0, errors = 0, steps_seen = 0, retired = 0, run = 0;
  logic [7:0] idx_m = '0;
  logic stopped_m = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;

  dbg_port u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .wdata(wdata), .wen(wen),
    .ack(ack), .rdata(rdata), .halt_req(halt_req), .step(step),
    .core_halted(core_halted), .nia(nia), .msr(msr), .cr(cr),
    .xer_so(so), .xer_ca(ca), .xer_ca32(ca32), .xer_ov(ov), .xer_ov32(ov32),
    .reg_sel(reg_sel), .reg_data(reg_data)
  );

  function automatic logic [63:0] regval(input logic [5:0] i);
    return 64'hC3A5_0000_0000_0000 ^ ({58'd0, i} * 64'h0001_0203_0405_0607);
  endfunction
  assign reg_data = regval(reg_sel);

  always @(posedge clk) begin
    if (!rst_n) begin
      core_halted <= 1'b0; run <= 0; retired <= 0;
    end else if (step) begin
      core_halted <= 1'b0; run <= 3;
    end else if (run != 0) begin
      run <= run - 1;
      if (run == 1) begin core_halted <= halt_req; retired <= retired + 1; end
    end else core_halted <= halt_req;
    if (rst_n && step) steps_seen <= steps_seen + 1;
  end

  function automatic logic [63:0] exp_read(input logic [3:0] a);
    case (a)
      4'd1: return {62'd0, stopped_m, 1'b0};
      4'd2: return nia;
      4'd3: return msr;
      4'd4: return {56'd0, idx_m};
      4'd5: return (idx_m <= 8'd45) ? regval(idx_m[5:0]) : 64'd0;
      4'd8: return cr;
      4'd9: return {58'd0, ov32, ov, ca32, ca, 1'b0, so};
      default: return 64'd0;
    endcase
  endfunction

  task automatic check(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic access(input logic [3:0] a, input logic [63:0] d, input logic w,
                        output logic [63:0] rd);
    addr = a; wdata = d; wen = w; req = 1'b1;
    @(negedge clk);
    check("R1 ack after one cycle", {63'd0, ack}, 64'd1);
    rd = rdata;
    req = 1'b0;
    @(negedge clk);
    check("R1 ack one cycle wide", {63'd0, ack}, 64'd0);
  endtask

  task automatic rd_check(input string r, input logic [3:0] a);
    logic [63:0] v;
    access(a, 64'd0, 1'b0, v);
    check(r, v, exp_read(a));
  endtask

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    logic [63:0] v;
    access(a, d, 1'b1, v);
  endtask

  task automatic wait_stopped(input string r);
    logic [63:0] v;
    for (int k = 0; k < 20; k++) begin
      access(4'd1, 64'd0, 1'b0, v);
      if (v == 64'd2) break;
    end
    stopped_m = 1'b1;
    check(r, v, 64'd2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    int r0, steps0;
    logic [63:0] v;
    r0 = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 ack", {63'd0, ack}, 64'd0);
    check("R10 halt_req", {63'd0, halt_req}, 64'd0);
    check("R10 step", {63'd0, step}, 64'd0);
    check("R10 reg_sel", {58'd0, reg_sel}, 64'd0);
    rd_check("R10 status", 4'd1);
    rd_check("R10 index", 4'd4);
    rd_check("R9 ctrl reads zero", 4'd0);

    for (int i = 0; i < 400; i++) begin
      int kind;
      logic [3:0] a;
      kind = $urandom_range(0, 9);
      nia = {$urandom, $urandom}; msr = {$urandom, $urandom}; cr = {$urandom, $urandom};
      {so, ca, ca32, ov, ov32} = 5'($urandom);
      if (kind < 2) begin
        idx_m = (kind == 0) ? 8'($urandom_range(0, 45)) : 8'($urandom);
        wr(4'd4, {$urandom, $urandom} & 64'hFFFF_FF00 | {56'd0, idx_m});
        check("R7 reg_sel", {58'd0, reg_sel}, {58'd0, idx_m[5:0]});
        rd_check(idx_m <= 8'd45 ? "R7 indexed read" : "R8 index out of range", 4'd5);
      end else if (kind == 2) begin
        do a = 4'($urandom); while (a <= 4'd5 || a == 4'd8 || a == 4'd9);
        wr(a, {$urandom, $urandom});
        check("R9 unmapped write halt_req", {63'd0, halt_req}, 64'd0);
        rd_check("R9 unmapped write index", 4'd4);
        rd_check("R9 unmapped write status", 4'd1);
      end else begin
        a = 4'($urandom);
        if (a == 4'd9) rd_check("R6 exception flags", a);
        else if (a inside {4'd2, 4'd3, 4'd8}) rd_check("R5 core state", a);
        else if (a == 4'd5) rd_check(idx_m <= 8'd45 ? "R7 data" : "R8 data", a);
        else rd_check("R9 unmapped or other read", a);
      end
    end

    idx_m = 8'd46; wr(4'd4, 64'd46); rd_check("R8 index 46", 4'd5);
    idx_m = 8'd45; wr(4'd4, 64'd45); rd_check("R7 index 45", 4'd5);
    idx_m = 8'd255; wr(4'd4, 64'hFF); rd_check("R8 index 255", 4'd5);
    {so, ca, ca32, ov, ov32} = 5'b10000; rd_check("R6 so bit 0", 4'd9);
    {so, ca, ca32, ov, ov32} = 5'b00101; rd_check("R6 ca32 ov32", 4'd9);

    steps0 = steps_seen;
    wr(4'd0, 64'h8);
    check("R4 step while running ignored", 64'(steps_seen - steps0), 64'd0);

    wr(4'd0, 64'h1);
    check("R2 halt_req", {63'd0, halt_req}, 64'd1);
    wait_stopped("R2 stopped bit");

    for (int s = 0; s < 3; s++) begin
      r0 = retired; steps0 = steps_seen;
      wr(4'd0, 64'h8);
      stopped_m = 1'b0;
      rd_check("R4 stopped clears on step", 4'd1);
      wait_stopped("R4 stopped returns");
      check("R4 one instruction", 64'(retired - r0), 64'd1);
      check("R4 one step pulse", 64'(steps_seen - steps0), 64'd1);
    end

    wr(4'd4, 64'd7); idx_m = 8'd7;
    wr(4'd6, 64'h3);
    check("R9 unmapped keeps halt", {63'd0, halt_req}, 64'd1);
    rd_check("R9 unmapped keeps status", 4'd1);

    wr(4'd0, 64'h3);
    check("R3 stop wins", {63'd0, halt_req}, 64'd1);
    wr(4'd0, 64'h2);
    stopped_m = 1'b0;
    check("R3 resume", {63'd0, halt_req}, 64'd0);
    rd_check("R3 status after resume", 4'd1);
    steps0 = steps_seen;
    wr(4'd0, 64'h8);
    repeat (4) @(negedge clk);
    check("R4 step after resume ignored", 64'(steps_seen - steps0), 64'd0);
    rd_check("R4 status stays clear", 4'd1);

    finish_run();
  end
endmodule